// File: doc/BRIEF.md
# Banked Data Memory Address Decoder

This block sits between a small 8-bit core and its data-memory targets. Every cycle it takes the core's 8-bit address and access strobe and steers the access to one target: the pointer registers it holds itself, the external special function registers, the external embedded control registers, the general-purpose RAM or the display memory. Addresses that are not assigned fall into a null target that reads zero and absorbs writes.

Two addresses are indirect windows. An access at 00H is carried out at the address held in pointer 0 (at 01H). An access at 02H is carried out at the address held in pointer 1 (at 03H). A bank register at 04H picks the RAM bank, but only pointer 1 accesses follow it. Direct accesses and pointer 0 accesses to 40H-FFH always land in bank 0. Through pointer 1 the bank register reaches every implemented bank and also the display-memory bank. Single-bit set and clear are done in one cycle as a read-modify-write of the resolved target.

The decode is combinational: selects, resolved address, bank and write data are valid in the same cycle as the strobe. Only the three pointer registers are clocked.

Top module: `data_mem_decoder`

## Requirements
- R1: After reset, pointer 0, pointer 1 and the bank register read 00H, and no target select is active while no strobe is given.
- R2: A direct access to 05H up to NUM_SFR-1 asserts `sfr_sel` and returns `sfr_rdata`. A direct access to 20H up to 20H+NUM_ECR-1 asserts `ecr_sel` and returns `ecr_rdata`. `tgt_addr` carries the address in both cases.
- R3: A direct access to the reserved ranges NUM_SFR to 1FH and 20H+NUM_ECR to 3FH asserts no select and no `tgt_we`, and a read returns 00H.
- R4: A direct access to 40H-FFH asserts `ram_sel` with `ram_bank` = 0, whatever the bank register holds.
- R5: A write at 01H, 03H or 04H loads pointer 0, pointer 1 or the bank register, and reads at those addresses return the stored value. No external `tgt_we` is given for these writes.
- R6: An access at 00H uses pointer 0 as the effective address. When that address is 40H or above, the access goes to RAM bank 0 whatever the bank register holds.
- R7: An access at 02H uses pointer 1 as the effective address. When that address is 40H or above and the bank register is below NUM_BANKS, `ram_sel` is asserted with `ram_bank` equal to the bank register. Below 40H the bank register plays no part.
- R8: An access at 02H with pointer 1 at 40H or above and the bank register equal to LCD_BANK (default 1BH) asserts `lcd_sel` with `tgt_addr` = pointer 1.
- R9: An access at 02H with pointer 1 at 40H or above and a bank register value that is neither an implemented bank nor LCD_BANK reads 00H and asserts no select and no `tgt_we`.
- R10: An indirect access whose pointer holds 00H or 02H reads 00H, asserts no select and leaves every pointer register unchanged.
- R11: `bit_set` (or `bit_clr`) with bit index `bit_sel` (0 = LSB) writes the target's current value with that bit forced to 1 (or 0) and all other bits unchanged. `rdata` shows the value before the change. This also applies to the pointer registers.
- R12: At most one of `sfr_sel`, `ecr_sel`, `ram_sel` and `lcd_sel` is active, none is active without a strobe, and `tgt_we` is only asserted together with a select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| bit_set | input | 1 | Single-bit set strobe |
| bit_clr | input | 1 | Single-bit clear strobe |
| bit_sel | input | 3 | Bit index for set or clear |
| addr | input | 8 | Direct address from the core |
| wdata | input | 8 | Write data from the core |
| rdata | output | 8 | Read data to the core, 00H when idle |
| sfr_rdata | input | 8 | Read data from the special function registers |
| ecr_rdata | input | 8 | Read data from the embedded control registers |
| ram_rdata | input | 8 | Read data from the general-purpose RAM |
| lcd_rdata | input | 8 | Read data from the display memory |
| sfr_sel | output | 1 | Special function register select |
| ecr_sel | output | 1 | Embedded control register select |
| ram_sel | output | 1 | General-purpose RAM select |
| lcd_sel | output | 1 | Display memory select |
| tgt_addr | output | 8 | Resolved effective address |
| ram_bank | output | BANK_W | RAM bank for `ram_sel` |
| tgt_we | output | 1 | Write enable to the selected external target |
| tgt_wdata | output | 8 | Write data, already merged for bit operations |

## Verification
The assertions take for granted that the core gives at most one of `rd`, `wr`, `bit_set` and `bit_clr` in a cycle. They also assume that the target read-data inputs depend only on the select, address and bank outputs of the same cycle. The bench keeps within this: it raises exactly one strobe per cycle, and it answers reads from memory models that look only at the decoder's own select, address and bank outputs.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

    typedef enum logic [2:0] {
        T_NONE,
        T_PTR0,
        T_PTR1,
        T_BANK,
        T_SFR,
        T_ECR,
        T_RAM,
        T_LCD
    } tgt_e;

    localparam logic [7:0] A_WIN0     = 8'h00;
    localparam logic [7:0] A_PTR0     = 8'h01;
    localparam logic [7:0] A_WIN1     = 8'h02;
    localparam logic [7:0] A_PTR1     = 8'h03;
    localparam logic [7:0] A_BANK     = 8'h04;
    localparam logic [7:0] A_ECR_BASE = 8'h20;
    localparam logic [7:0] A_RAM_BASE = 8'h40;

    typedef struct packed {
        logic       loop;
        logic       via1;
        logic [7:0] eaddr;
    } res_t;

    typedef struct packed {
        tgt_e       kind;
        logic [7:0] addr;
    } dec_t;

    function automatic logic [7:0] merge_bit(input logic [7:0] old,
                                             input logic [2:0] idx,
                                             input logic       set_not_clr);
        logic [7:0] mask;
        mask = 8'h01 << idx;
        return set_not_clr ? (old | mask) : (old & ~mask);
    endfunction

endpackage

// File: rtl/dmd_ptr_regs.sv
module dmd_ptr_regs (
    input  logic       clk,
    input  logic       rst,
    input  logic       ld_ptr0,
    input  logic       ld_ptr1,
    input  logic       ld_bank,
    input  logic [7:0] din,
    output logic [7:0] ptr0_q,
    output logic [7:0] ptr1_q,
    output logic [7:0] bank_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr0_q <= '0;
            ptr1_q <= '0;
            bank_q <= '0;
        end else begin
            if (ld_ptr0) ptr0_q <= din;
            if (ld_ptr1) ptr1_q <= din;
            if (ld_bank) bank_q <= din;
        end
    end
endmodule

// File: rtl/dmd_resolve.sv
module dmd_resolve
    import dmd_pkg::*;
(
    input  logic [7:0] addr,
    input  logic [7:0] ptr0_q,
    input  logic [7:0] ptr1_q,
    output res_t       res
);
    always_comb begin
        res.via1  = 1'b0;
        res.loop  = 1'b0;
        res.eaddr = addr;
        if (addr == A_WIN0) begin
            res.eaddr = ptr0_q;
            res.loop  = (ptr0_q == A_WIN0) || (ptr0_q == A_WIN1);
        end else if (addr == A_WIN1) begin
            res.eaddr = ptr1_q;
            res.via1  = 1'b1;
            res.loop  = (ptr1_q == A_WIN0) || (ptr1_q == A_WIN1);
        end
    end
endmodule

// File: rtl/dmd_classify.sv
module dmd_classify
    import dmd_pkg::*;
#(
    parameter int          NUM_SFR   = 12,
    parameter int          NUM_ECR   = 24,
    parameter int          NUM_BANKS = 6,
    parameter logic [7:0]  LCD_BANK  = 8'h1B,
    parameter int          BANK_W    = 3
) (
    input  res_t                res,
    input  logic [7:0]          bank_q,
    output dec_t                dec,
    output logic [BANK_W-1:0]   ram_bank
);
    localparam logic [7:0] SFR_END = 8'(NUM_SFR);
    localparam logic [7:0] ECR_END = 8'(32 + NUM_ECR);
    localparam logic [7:0] NB      = 8'(NUM_BANKS);

    always_comb begin
        dec.addr = res.eaddr;
        dec.kind = T_NONE;
        ram_bank = '0;
        if (res.loop) begin
            dec.kind = T_NONE;
        end else if (res.eaddr == A_PTR0) begin
            dec.kind = T_PTR0;
        end else if (res.eaddr == A_PTR1) begin
            dec.kind = T_PTR1;
        end else if (res.eaddr == A_BANK) begin
            dec.kind = T_BANK;
        end else if (res.eaddr < A_ECR_BASE) begin
            if (res.eaddr > A_BANK && res.eaddr < SFR_END) dec.kind = T_SFR;
        end else if (res.eaddr < A_RAM_BASE) begin
            if (res.eaddr < ECR_END) dec.kind = T_ECR;
        end else if (!res.via1) begin
            dec.kind = T_RAM;
        end else if (bank_q < NB) begin
            dec.kind = T_RAM;
            ram_bank = bank_q[BANK_W-1:0];
        end else if (bank_q == LCD_BANK) begin
            dec.kind = T_LCD;
        end
    end
endmodule

// File: rtl/data_mem_decoder.sv
module data_mem_decoder
    import dmd_pkg::*;
#(
    parameter int          NUM_SFR   = 12,
    parameter int          NUM_ECR   = 24,
    parameter int          NUM_BANKS = 6,
    parameter logic [7:0]  LCD_BANK  = 8'h1B,
    parameter int          BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic              wr,
    input  logic              bit_set,
    input  logic              bit_clr,
    input  logic [2:0]        bit_sel,
    input  logic [7:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [7:0]        sfr_rdata,
    input  logic [7:0]        ecr_rdata,
    input  logic [7:0]        ram_rdata,
    input  logic [7:0]        lcd_rdata,
    output logic              sfr_sel,
    output logic              ecr_sel,
    output logic              ram_sel,
    output logic              lcd_sel,
    output logic [7:0]        tgt_addr,
    output logic [BANK_W-1:0] ram_bank,
    output logic              tgt_we,
    output logic [7:0]        tgt_wdata
);
    logic [7:0]        ptr0_q, ptr1_q, bank_q;
    res_t              res;
    dec_t              dec;
    logic [BANK_W-1:0] bank_dec;
    logic              access, modify, writing, external;
    logic [7:0]        cur_val, new_val;

    assign modify  = bit_set | bit_clr;
    assign writing = wr | modify;
    assign access  = rd | writing;

    dmd_resolve u_resolve (
        .addr   (addr),
        .ptr0_q (ptr0_q),
        .ptr1_q (ptr1_q),
        .res    (res)
    );

    dmd_classify #(
        .NUM_SFR   (NUM_SFR),
        .NUM_ECR   (NUM_ECR),
        .NUM_BANKS (NUM_BANKS),
        .LCD_BANK  (LCD_BANK),
        .BANK_W    (BANK_W)
    ) u_classify (
        .res      (res),
        .bank_q   (bank_q),
        .dec      (dec),
        .ram_bank (bank_dec)
    );

    always_comb begin
        unique case (dec.kind)
            T_PTR0:  cur_val = ptr0_q;
            T_PTR1:  cur_val = ptr1_q;
            T_BANK:  cur_val = bank_q;
            T_SFR:   cur_val = sfr_rdata;
            T_ECR:   cur_val = ecr_rdata;
            T_RAM:   cur_val = ram_rdata;
            T_LCD:   cur_val = lcd_rdata;
            default: cur_val = '0;
        endcase
    end

    always_comb begin
        if (modify) new_val = merge_bit(cur_val, bit_sel, bit_set);
        else        new_val = wdata;
    end

    assign sfr_sel   = access && dec.kind == T_SFR;
    assign ecr_sel   = access && dec.kind == T_ECR;
    assign ram_sel   = access && dec.kind == T_RAM;
    assign lcd_sel   = access && dec.kind == T_LCD;
    assign external  = sfr_sel | ecr_sel | ram_sel | lcd_sel;
    assign tgt_we    = writing && external;
    assign tgt_wdata = new_val;
    assign tgt_addr  = dec.addr;
    assign ram_bank  = ram_sel ? bank_dec : '0;
    assign rdata     = access ? cur_val : '0;

    dmd_ptr_regs u_ptrs (
        .clk     (clk),
        .rst     (rst),
        .ld_ptr0 (writing && dec.kind == T_PTR0),
        .ld_ptr1 (writing && dec.kind == T_PTR1),
        .ld_bank (writing && dec.kind == T_BANK),
        .din     (new_val),
        .ptr0_q  (ptr0_q),
        .ptr1_q  (ptr1_q),
        .bank_q  (bank_q)
    );
endmodule

// File: rtl/dmd_checker.sv
module dmd_checker #(
    parameter int         NUM_SFR   = 12,
    parameter int         NUM_ECR   = 24,
    parameter int         NUM_BANKS = 6,
    parameter logic [7:0] LCD_BANK  = 8'h1B,
    parameter int         BANK_W    = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              rd,
    input logic              wr,
    input logic              bit_set,
    input logic              bit_clr,
    input logic [2:0]        bit_sel,
    input logic [7:0]        addr,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input logic              sfr_sel,
    input logic              ecr_sel,
    input logic              ram_sel,
    input logic              lcd_sel,
    input logic [BANK_W-1:0] ram_bank,
    input logic              tgt_we,
    input logic [7:0]        tgt_wdata,
    input logic [7:0]        ptr0_q,
    input logic [7:0]        ptr1_q,
    input logic [7:0]        bank_q
);
    localparam logic [7:0] SFR_END = 8'(NUM_SFR);
    localparam logic [7:0] ECR_END = 8'(32 + NUM_ECR);
    localparam logic [7:0] NB      = 8'(NUM_BANKS);

    logic any_acc, any_sel, reserved, hi1;
    assign any_acc  = rd | wr | bit_set | bit_clr;
    assign any_sel  = sfr_sel | ecr_sel | ram_sel | lcd_sel;
    assign reserved = (addr >= SFR_END && addr < 8'h20) ||
                      (addr >= ECR_END && addr < 8'h40);
    assign hi1      = any_acc && addr == 8'h02 && ptr1_q >= 8'h40;

    assert_one_target_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sfr_sel, ecr_sel, ram_sel, lcd_sel}));
    assert_sel_needs_strobe_R12: assert property (@(posedge clk) disable iff (rst)
        any_sel |-> any_acc);
    assert_we_needs_sel_R12: assert property (@(posedge clk) disable iff (rst)
        tgt_we |-> any_sel);
    assert_reserved_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (any_acc && reserved) |-> (!any_sel && !tgt_we && rdata == 8'h00));
    assert_direct_bank0_R4: assert property (@(posedge clk) disable iff (rst)
        (any_acc && addr >= 8'h40) |-> (ram_sel && ram_bank == '0));
    assert_ptr1_load_R5: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 8'h03) |=> (ptr1_q == $past(wdata)));
    assert_ptr0_bank0_R6: assert property (@(posedge clk) disable iff (rst)
        (any_acc && addr == 8'h00 && ptr0_q >= 8'h40) |-> (ram_sel && ram_bank == '0));
    assert_bank_follow_R7: assert property (@(posedge clk) disable iff (rst)
        (hi1 && bank_q < NB) |-> (ram_sel && ram_bank == bank_q[BANK_W-1:0]));
    assert_display_R8: assert property (@(posedge clk) disable iff (rst)
        (hi1 && bank_q == LCD_BANK) |-> lcd_sel);
    assert_bad_bank_R9: assert property (@(posedge clk) disable iff (rst)
        (hi1 && bank_q >= NB && bank_q != LCD_BANK) |-> (!any_sel && !tgt_we && rdata == 8'h00));
    assert_loop_R10: assert property (@(posedge clk) disable iff (rst)
        (any_acc && addr == 8'h02 && (ptr1_q == 8'h00 || ptr1_q == 8'h02))
        |=> ($stable(ptr0_q) && $stable(ptr1_q) && $stable(bank_q)));
    assert_bit_set_R11: assert property (@(posedge clk) disable iff (rst)
        (bit_set && tgt_we) |-> (tgt_wdata[bit_sel] &&
            ((tgt_wdata | (8'h01 << bit_sel)) == (rdata | (8'h01 << bit_sel)))));
    assert_bit_clr_R11: assert property (@(posedge clk) disable iff (rst)
        (bit_clr && tgt_we) |-> (!tgt_wdata[bit_sel] &&
            ((tgt_wdata & ~(8'h01 << bit_sel)) == (rdata & ~(8'h01 << bit_sel)))));
endmodule

bind data_mem_decoder dmd_checker #(
    .NUM_SFR   (NUM_SFR),
    .NUM_ECR   (NUM_ECR),
    .NUM_BANKS (NUM_BANKS),
    .LCD_BANK  (LCD_BANK),
    .BANK_W    (BANK_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd        (rd),
    .wr        (wr),
    .bit_set   (bit_set),
    .bit_clr   (bit_clr),
    .bit_sel   (bit_sel),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .sfr_sel   (sfr_sel),
    .ecr_sel   (ecr_sel),
    .ram_sel   (ram_sel),
    .lcd_sel   (lcd_sel),
    .ram_bank  (ram_bank),
    .tgt_we    (tgt_we),
    .tgt_wdata (tgt_wdata),
    .ptr0_q    (ptr0_q),
    .ptr1_q    (ptr1_q),
    .bank_q    (bank_q)
);

// File: tb/tb_data_mem_decoder.sv
`timescale 1ns/1ps
module tb_data_mem_decoder;
    localparam int NB  = 6;
    localparam int BW  = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd = 0, wr = 0, bit_set = 0, bit_clr = 0;
    logic [2:0]    bit_sel = '0;
    logic [7:0]    addr = '0, wdata = '0;
    logic [7:0]    rdata, sfr_rdata, ecr_rdata, ram_rdata, lcd_rdata;
    logic          sfr_sel, ecr_sel, ram_sel, lcd_sel, tgt_we;
    logic [7:0]    tgt_addr, tgt_wdata;
    logic [BW-1:0] ram_bank;

    always #4 clk = ~clk;

    data_mem_decoder dut (
        .clk(clk), .rst(rst), .rd(rd), .wr(wr), .bit_set(bit_set), .bit_clr(bit_clr),
        .bit_sel(bit_sel), .addr(addr), .wdata(wdata), .rdata(rdata),
        .sfr_rdata(sfr_rdata), .ecr_rdata(ecr_rdata), .ram_rdata(ram_rdata),
        .lcd_rdata(lcd_rdata), .sfr_sel(sfr_sel), .ecr_sel(ecr_sel), .ram_sel(ram_sel),
        .lcd_sel(lcd_sel), .tgt_addr(tgt_addr), .ram_bank(ram_bank), .tgt_we(tgt_we),
        .tgt_wdata(tgt_wdata)
    );

    // target models
    logic [7:0] sfr_m [32];
    logic [7:0] ecr_m [32];
    logic [7:0] ram_m [NB*256];
    logic [7:0] lcd_m [256];

    function automatic logic [7:0] pat_sfr(input int a); return 8'hA0 ^ 8'(a); endfunction
    function automatic logic [7:0] pat_ecr(input int a); return 8'h5C ^ 8'(a); endfunction
    function automatic logic [7:0] pat_ram(input int b, input int a); return 8'(a + b * 37); endfunction
    function automatic logic [7:0] pat_lcd(input int a); return ~8'(a); endfunction

    initial begin
        for (int i = 0; i < 32; i++) begin sfr_m[i] = pat_sfr(i); ecr_m[i] = pat_ecr(i + 32); end
        for (int b = 0; b < NB; b++)
            for (int a = 0; a < 256; a++) ram_m[b*256 + a] = pat_ram(b, a);
        for (int a = 0; a < 256; a++) lcd_m[a] = pat_lcd(a);
    end

    assign sfr_rdata = sfr_m[tgt_addr[4:0]];
    assign ecr_rdata = ecr_m[tgt_addr[4:0]];
    assign ram_rdata = (int'(ram_bank) < NB) ? ram_m[int'(ram_bank)*256 + int'(tgt_addr)] : 8'h00;
    assign lcd_rdata = lcd_m[tgt_addr];

    always @(posedge clk) begin
        if (tgt_we) begin
            if (sfr_sel) sfr_m[tgt_addr[4:0]] <= tgt_wdata;
            if (ecr_sel) ecr_m[tgt_addr[4:0]] <= tgt_wdata;
            if (ram_sel && int'(ram_bank) < NB) ram_m[int'(ram_bank)*256 + int'(tgt_addr)] <= tgt_wdata;
            if (lcd_sel) lcd_m[tgt_addr] <= tgt_wdata;
        end
    end

    int n_chk = 0, n_bad = 0;
    logic [7:0]    s_rdata, s_addr, s_wdata;
    logic [3:0]    s_sel;
    logic [BW-1:0] s_bank;
    logic          s_we;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one access cycle: drive at negedge, sample just after, commit at posedge
    task automatic cyc(input logic r, input logic w, input logic s, input logic c,
                       input logic [2:0] b, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        rd = r; wr = w; bit_set = s; bit_clr = c; bit_sel = b; addr = a; wdata = d;
        #1;
        s_rdata = rdata; s_addr = tgt_addr; s_wdata = tgt_wdata;
        s_sel = {sfr_sel, ecr_sel, ram_sel, lcd_sel}; s_bank = ram_bank; s_we = tgt_we;
        @(posedge clk); #1;
        rd = 0; wr = 0; bit_set = 0; bit_clr = 0;
    endtask

    task automatic rd_at(input logic [7:0] a);  cyc(1, 0, 0, 0, 3'd0, a, 8'h00); endtask
    task automatic wr_at(input logic [7:0] a, input logic [7:0] d); cyc(0, 1, 0, 0, 3'd0, a, d); endtask

    task automatic t_reset;
        @(negedge clk); #1;
        chk("R1 idle selects", {sfr_sel, ecr_sel, ram_sel, lcd_sel, tgt_we}, 0);
        chk("R1 idle rdata", rdata, 8'h00);
        rd_at(8'h01); chk("R1 ptr0 reset", s_rdata, 8'h00);
        rd_at(8'h03); chk("R1 ptr1 reset", s_rdata, 8'h00);
        rd_at(8'h04); chk("R1 bank reset", s_rdata, 8'h00);
    endtask

    task automatic t_regions;
        rd_at(8'h05); chk("R2 sfr sel", s_sel, 4'b1000); chk("R2 sfr data", s_rdata, pat_sfr(5));
        chk("R2 sfr addr", s_addr, 8'h05);
        rd_at(8'h0B); chk("R2 last sfr", s_rdata, pat_sfr(11));
        rd_at(8'h20); chk("R2 ecr sel", s_sel, 4'b0100); chk("R2 ecr data", s_rdata, pat_ecr(32));
        rd_at(8'h37); chk("R2 last ecr", s_rdata, pat_ecr(55));
        wr_at(8'h21, 8'h99); rd_at(8'h21); chk("R2 ecr write", s_rdata, 8'h99);
    endtask

    task automatic t_reserved;
        foreach (sfr_m[i]) begin end
        rd_at(8'h0C); chk("R3 read 0C", {s_sel, s_rdata}, 12'h000);
        rd_at(8'h1F); chk("R3 read 1F", {s_sel, s_rdata}, 12'h000);
        rd_at(8'h38); chk("R3 read 38", {s_sel, s_rdata}, 12'h000);
        wr_at(8'h3F, 8'h77); chk("R3 write 3F no we", {s_sel, s_we}, 5'b0);
        rd_at(8'h3F); chk("R3 read 3F after write", s_rdata, 8'h00);
    endtask

    task automatic t_ptr_load;
        wr_at(8'h01, 8'h45); chk("R5 no we on ptr write", s_we, 1'b0);
        rd_at(8'h01); chk("R5 ptr0 readback", s_rdata, 8'h45);
        wr_at(8'h03, 8'hC3); rd_at(8'h03); chk("R5 ptr1 readback", s_rdata, 8'hC3);
        wr_at(8'h04, 8'h02); rd_at(8'h04); chk("R5 bank readback", s_rdata, 8'h02);
    endtask

    task automatic t_direct_ram;
        wr_at(8'h04, 8'h03);
        rd_at(8'h40); chk("R4 ram sel", s_sel, 4'b0010); chk("R4 bank0", s_bank, 0);
        chk("R4 data 40", s_rdata, pat_ram(0, 8'h40));
        rd_at(8'hFF); chk("R4 data FF", s_rdata, pat_ram(0, 8'hFF));
    endtask

    task automatic t_ind0;
        wr_at(8'h04, 8'h03); wr_at(8'h01, 8'h77);
        rd_at(8'h00); chk("R6 ptr0 ram bank0", {s_sel, 4'(s_bank)}, {4'b0010, 4'd0});
        chk("R6 ptr0 data", s_rdata, pat_ram(0, 8'h77));
        chk("R6 ptr0 addr", s_addr, 8'h77);
        wr_at(8'h00, 8'h3A); rd_at(8'h77); chk("R6 write via ptr0", s_rdata, 8'h3A);
        wr_at(8'h01, 8'h06); rd_at(8'h00); chk("R6 ptr0 to sfr", s_rdata, pat_sfr(6));
    endtask

    task automatic t_ind1;
        wr_at(8'h03, 8'h90); wr_at(8'h04, 8'h05);
        rd_at(8'h02); chk("R7 ptr1 bank5 sel", {s_sel, 4'(s_bank)}, {4'b0010, 4'd5});
        chk("R7 ptr1 bank5 data", s_rdata, pat_ram(5, 8'h90));
        wr_at(8'h02, 8'h5E); rd_at(8'h02); chk("R7 bank5 writeback", s_rdata, 8'h5E);
        wr_at(8'h04, 8'h00); rd_at(8'h02); chk("R7 ptr1 bank0 data", s_rdata, pat_ram(0, 8'h90));
        wr_at(8'h04, 8'h09); wr_at(8'h03, 8'h22);
        rd_at(8'h02); chk("R7 low addr ignores bank", {s_sel, s_rdata}, {4'b0100, pat_ecr(34)});
    endtask

    task automatic t_display;
        wr_at(8'h04, 8'h1B); wr_at(8'h03, 8'h50);
        rd_at(8'h02); chk("R8 lcd sel", s_sel, 4'b0001); chk("R8 lcd addr", s_addr, 8'h50);
        chk("R8 lcd data", s_rdata, pat_lcd(8'h50));
        wr_at(8'h02, 8'h3C); rd_at(8'h02); chk("R8 lcd write", s_rdata, 8'h3C);
    endtask

    task automatic t_bad_bank;
        wr_at(8'h03, 8'h60); wr_at(8'h04, 8'h06);
        rd_at(8'h02); chk("R9 bank6 read", {s_sel, s_rdata}, 12'h000);
        wr_at(8'h02, 8'hEE); chk("R9 bank6 no we", {s_sel, s_we}, 5'b0);
        wr_at(8'h04, 8'h1A);
        rd_at(8'h02); chk("R9 bank1A read", {s_sel, s_rdata}, 12'h000);
        wr_at(8'h04, 8'h00); rd_at(8'h02); chk("R9 bank0 untouched", s_rdata, pat_ram(0, 8'h60));
    endtask

    task automatic t_loop;
        wr_at(8'h01, 8'h00); rd_at(8'h00); chk("R10 ptr0=00 read", {s_sel, s_rdata}, 12'h000);
        wr_at(8'h01, 8'h02); rd_at(8'h00); chk("R10 ptr0=02 read", {s_sel, s_rdata}, 12'h000);
        wr_at(8'h03, 8'h02); wr_at(8'h02, 8'h55); chk("R10 ptr1 loop no we", {s_sel, s_we}, 5'b0);
        rd_at(8'h03); chk("R10 ptr1 unchanged", s_rdata, 8'h02);
        rd_at(8'h01); chk("R10 ptr0 unchanged", s_rdata, 8'h02);
    endtask

    task automatic t_bitops;
        cyc(0, 0, 1, 0, 3'd3, 8'h45, 8'h00);
        chk("R11 set old value", s_rdata, pat_ram(0, 8'h45));
        chk("R11 set wdata", s_wdata, pat_ram(0, 8'h45) | 8'h08); chk("R11 set we", s_we, 1'b1);
        rd_at(8'h45); chk("R11 set stored", s_rdata, pat_ram(0, 8'h45) | 8'h08);
        wr_at(8'h03, 8'hFF); cyc(0, 0, 0, 1, 3'd1, 8'h03, 8'h00);
        rd_at(8'h03); chk("R11 clr on ptr1", s_rdata, 8'hFD);
        wr_at(8'h03, 8'hA0); wr_at(8'h04, 8'h02);
        cyc(0, 0, 0, 1, 3'd7, 8'h02, 8'h00);
        rd_at(8'h02); chk("R11 clr bank2 via ptr1", s_rdata, pat_ram(2, 8'hA0) & 8'h7F);
        cyc(0, 0, 1, 0, 3'd0, 8'h08, 8'h00); rd_at(8'h08);
        chk("R11 set sfr bit0", s_rdata, pat_sfr(8) | 8'h01);
    endtask

    task automatic t_exclusive;
        wr_at(8'h04, 8'h01);
        for (int a = 0; a < 256; a++) begin
            rd_at(8'(a));
            chk("R12 one select", ($countones(s_sel) <= 1) ? 1 : 0, 1);
            chk("R12 no we on read", s_we, 1'b0);
        end
    endtask

    logic done = 1'b0;
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset;
        t_regions;
        t_reserved;
        t_ptr_load;
        t_direct_ram;
        t_ind0;
        t_ind1;
        t_display;
        t_bad_bank;
        t_loop;
        t_bitops;
        t_exclusive;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule